// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers every interrupt source of a UART and turns them into one status view and one interrupt line. The receive and transmit FIFO fill levels arrive as counts and are compared with programmable trigger points. The receive source fires when the receive fill level climbs up to its trigger point. The transmit source fires when the transmit fill level drains down to its trigger point. Single-cycle pulses for overrun, break, parity error, framing error, receive timeout and a change of the clear-to-send line set their own sticky status bits.

Software reaches the block through a small register port. Writes are synchronous with `reg_we`. Reads are combinational from `reg_addr`. There are five registers: address 0 holds the trigger-point selects, address 1 the enable mask, address 2 the raw status, address 3 the masked status, and address 4 the write-one-to-clear register, which reads as zero.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the trigger-select register reads 0x012 (both fields at code 010), the mask and raw status read 0, and `irq` is low.
- R2: The trigger-select register holds the transmit code in bits [2:0] and the receive code in bits [5:3]. The trigger point is DEPTH·k/8, where code 000 gives k=1, 001 gives k=2, 010 gives k=4, 011 gives k=6 and 100 gives k=7. The reserved codes 101, 110 and 111 act as k=4.
- R3: Raw bit 4 (receive) is set at the clock edge where `rx_level` is at or above the receive trigger point and the value sampled at the previous edge was below it. A level that stays at or above the trigger point does not set the bit again.
- R4: Raw bit 5 (transmit) is set at the clock edge where `tx_level` is at or below the transmit trigger point and the value sampled at the previous edge was above it.
- R5: Event pulses set these raw bits at the next edge: overrun sets bit 10, break sets bit 9, parity sets bit 8, framing sets bit 7, receive timeout sets bit 6 and CTS change sets bit 1. Raw bits 0, 2 and 3 always read 0.
- R6: A write to address 1 loads the mask from the write data, restricted to bits 10..4 and 1. A read of address 1 returns the current mask.
- R7: A read of address 3 returns the raw status ANDed with the mask.
- R8: A write to address 4 clears each raw bit whose data bit is 1. Bits written as 0 keep their value, and raw bits stay set until they are cleared.
- R9: When an event for a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R10: `irq` is high exactly when at least one masked status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Register read data (combinational) |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill count |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO fill count |
| evt_overrun | input | 1 | Overrun event pulse |
| evt_break | input | 1 | Break event pulse |
| evt_parity | input | 1 | Parity error event pulse |
| evt_framing | input | 1 | Framing error event pulse |
| evt_rx_timeout | input | 1 | Receive timeout event pulse |
| evt_cts_change | input | 1 | Clear-to-send change event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a trigger firing only on a crossing and never on a level that is held. To get there, the stimulus walks the fill counts one step per cycle up to and past the trigger point, then holds them there. It does this for several select codes, including a reserved one. Before a new code is written, the counts are parked where no crossing can occur. A second hard case is an event landing in the very cycle its bit is cleared; a combined task drives the pulse and the clear write on the same edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ST_W = 11;

  localparam int ST_OVR  = 10;
  localparam int ST_BRK  = 9;
  localparam int ST_PAR  = 8;
  localparam int ST_FRM  = 7;
  localparam int ST_RTO  = 6;
  localparam int ST_TX   = 5;
  localparam int ST_RX   = 4;
  localparam int ST_CTS  = 1;

  localparam logic [ST_W-1:0] ST_VALID = 11'b111_1111_0010;

  localparam logic [2:0] RA_LVL    = 3'd0;
  localparam logic [2:0] RA_MASK   = 3'd1;
  localparam logic [2:0] RA_RAW    = 3'd2;
  localparam logic [2:0] RA_MASKED = 3'd3;
  localparam logic [2:0] RA_CLEAR  = 3'd4;

  localparam logic [5:0] LVL_RESET = 6'b010_010;

  // Eighths of the FIFO depth selected by a 3-bit trigger code.
  function automatic int unsigned sel_eighths(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 7;
      default: return 4;
    endcase
  endfunction

  function automatic int unsigned trig_point(input logic [2:0] code, input int unsigned depth);
    return (depth / 8) * sel_eighths(code);
  endfunction

endpackage

// File: rtl/irq_lvl_cross.sv
module irq_lvl_cross #(
  parameter int LVL_W  = 5,
  parameter bit RISING = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr,
  output logic             fire
);

  logic [LVL_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  generate
    if (RISING) begin : g_up
      assign fire = (prev_q < thr) && (level >= thr);
    end else begin : g_down
      assign fire = (prev_q > thr) && (level <= thr);
    end
  endgenerate

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int         W     = 11,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] mask_q
);

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (VALID[i]) begin : g_live
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            raw_q[i]  <= 1'b0;
            mask_q[i] <= 1'b0;
          end else begin
            // a new event takes priority over a clear in the same cycle
            raw_q[i] <= set_vec[i] | (raw_q[i] & ~clr_vec[i]);
            if (mask_we) mask_q[i] <= mask_wdata[i];
          end
        end
      end else begin : g_tied
        assign raw_q[i]  = 1'b0;
        assign mask_q[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [ST_W-1:0]  reg_wdata,
  output logic [ST_W-1:0]  reg_rdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             evt_overrun,
  input  logic             evt_break,
  input  logic             evt_parity,
  input  logic             evt_framing,
  input  logic             evt_rx_timeout,
  input  logic             evt_cts_change,
  output logic             irq
);

  logic [5:0]       lvl_q;
  logic [2:0]       tx_sel, rx_sel;
  logic [LVL_W-1:0] rx_thr, tx_thr;
  logic             rx_fire, tx_fire;
  logic [ST_W-1:0]  set_vec, clr_vec;
  logic [ST_W-1:0]  raw_q, mask_q, masked;
  logic             mask_we, lvl_we, clr_we;

  assign mask_we = reg_we && (reg_addr == RA_MASK);
  assign lvl_we  = reg_we && (reg_addr == RA_LVL);
  assign clr_we  = reg_we && (reg_addr == RA_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= LVL_RESET;
    else if (lvl_we) lvl_q <= reg_wdata[5:0];
  end

  assign tx_sel = lvl_q[2:0];
  assign rx_sel = lvl_q[5:3];
  assign rx_thr = LVL_W'(trig_point(rx_sel, DEPTH));
  assign tx_thr = LVL_W'(trig_point(tx_sel, DEPTH));

  irq_lvl_cross #(.LVL_W(LVL_W), .RISING(1'b1)) u_rx_cross (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .thr(rx_thr), .fire(rx_fire)
  );

  irq_lvl_cross #(.LVL_W(LVL_W), .RISING(1'b0)) u_tx_cross (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .thr(tx_thr), .fire(tx_fire)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[ST_OVR] = evt_overrun;
    set_vec[ST_BRK] = evt_break;
    set_vec[ST_PAR] = evt_parity;
    set_vec[ST_FRM] = evt_framing;
    set_vec[ST_RTO] = evt_rx_timeout;
    set_vec[ST_TX]  = tx_fire;
    set_vec[ST_RX]  = rx_fire;
    set_vec[ST_CTS] = evt_cts_change;
  end

  assign clr_vec = clr_we ? reg_wdata : '0;

  irq_status_bank #(.W(ST_W), .VALID(ST_VALID)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_wdata(reg_wdata), .raw_q(raw_q), .mask_q(mask_q)
  );

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  always_comb begin
    case (reg_addr)
      RA_LVL:    reg_rdata = {{(ST_W-6){1'b0}}, lvl_q};
      RA_MASK:   reg_rdata = mask_q;
      RA_RAW:    reg_rdata = raw_q;
      RA_MASKED: reg_rdata = masked;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [ST_W-1:0] reg_wdata,
  input logic            evt_overrun,
  input logic            rx_fire,
  input logic            tx_fire,
  input logic [ST_W-1:0] clr_vec,
  input logic [ST_W-1:0] raw_q,
  input logic [ST_W-1:0] mask_q,
  input logic            irq
);

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[0] == 1'b0) && (raw_q[2] == 1'b0) && (raw_q[3] == 1'b0)); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |=> raw_q[ST_OVR]); // R9
  AST_RX_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> raw_q[ST_RX]); // R3
  AST_TX_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> raw_q[ST_TX]); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[ST_RX] && !rx_fire) |=> !raw_q[ST_RX]); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q[ST_OVR] && !clr_vec[ST_OVR]) |=> raw_q[ST_OVR]); // R8
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_MASK) |=> (mask_q == ($past(reg_wdata) & ST_VALID))); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & mask_q) == '0) |-> !irq); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_q & mask_q) != '0)); // R10

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_overrun(evt_overrun), .rx_fire(rx_fire),
  .tx_fire(tx_fire), .clr_vec(clr_vec), .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;

  localparam int DEPTH = 16;
  localparam int LW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [10:0]   reg_wdata = '0;
  logic [10:0]   reg_rdata;
  logic [LW-1:0] rx_level = '0, tx_level = '0;
  logic evt_overrun = 0, evt_break = 0, evt_parity = 0, evt_framing = 0;
  logic evt_rx_timeout = 0, evt_cts_change = 0;
  logic irq;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
    .tx_level(tx_level), .evt_overrun(evt_overrun), .evt_break(evt_break),
    .evt_parity(evt_parity), .evt_framing(evt_framing),
    .evt_rx_timeout(evt_rx_timeout), .evt_cts_change(evt_cts_change), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  int m_raw, m_mask, m_lvl, m_prx, m_ptx;

  function automatic int thr_of(input int code);
    int k;
    if      (code == 0) k = 1;
    else if (code == 1) k = 2;
    else if (code == 2) k = 4;
    else if (code == 3) k = 6;
    else if (code == 4) k = 7;
    else                k = 4;
    return DEPTH * k / 8;
  endfunction

  function automatic int model_read(input int a);
    if (a == 0) return m_lvl;
    if (a == 1) return m_mask;
    if (a == 2) return m_raw;
    if (a == 3) return m_raw & m_mask;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = 0; m_mask = 0; m_lvl = 'h12; m_prx = 0; m_ptx = 0;
    end else begin
      int trx, ttx, ev, clr;
      trx = thr_of((m_lvl >> 3) & 7);
      ttx = thr_of(m_lvl & 7);
      ev = 0;
      if (m_prx < trx && int'(rx_level) >= trx) ev += 'h010;
      if (m_ptx > ttx && int'(tx_level) <= ttx) ev += 'h020;
      if (evt_overrun)    ev += 'h400;
      if (evt_break)      ev += 'h200;
      if (evt_parity)     ev += 'h100;
      if (evt_framing)    ev += 'h080;
      if (evt_rx_timeout) ev += 'h040;
      if (evt_cts_change) ev += 'h002;
      clr = (reg_we && reg_addr == 3'd4) ? int'(reg_wdata) : 0;
      m_raw = ((m_raw & ~clr) | ev) & 'h7F2;
      if (reg_we && reg_addr == 3'd1) m_mask = int'(reg_wdata) & 'h7F2;
      if (reg_we && reg_addr == 3'd0) m_lvl  = int'(reg_wdata) & 'h3F;
      m_prx = int'(rx_level);
      m_ptx = int'(tx_level);
    end
  end

  // compared every cycle, mid-period
  always @(negedge clk) begin
    if (rst_n) begin
      vectors += 2;
      if (int'(irq) != ((m_raw & m_mask) != 0 ? 1 : 0)) begin
        errors++;
        $display("FAIL R10 model irq: actual %0d expected %0d", irq, (m_raw & m_mask) != 0);
      end
      if (int'(reg_rdata) != model_read(int'(reg_addr))) begin
        errors++;
        $display("FAIL R6/R7 model read addr %0d: actual %h expected %h",
                 reg_addr, reg_rdata, model_read(int'(reg_addr)));
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input logic [2:0] a, input logic [10:0] exp, input string tag);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk);
    vectors++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    vectors++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %0d expected %0d", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] d);
    @(posedge clk); #1 reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic set_rx(input int v);
    @(posedge clk); #1 rx_level = LW'(v);
  endtask

  task automatic set_tx(input int v);
    @(posedge clk); #1 tx_level = LW'(v);
  endtask

  task automatic pulse(input int which, input logic clr_too, input logic [10:0] cd);
    @(posedge clk); #1;
    case (which)
      10: evt_overrun = 1;
      9:  evt_break = 1;
      8:  evt_parity = 1;
      7:  evt_framing = 1;
      6:  evt_rx_timeout = 1;
      default: evt_cts_change = 1;
    endcase
    if (clr_too) begin reg_addr = 3'd4; reg_wdata = cd; reg_we = 1'b1; end
    @(posedge clk); #1;
    {evt_overrun, evt_break, evt_parity, evt_framing, evt_rx_timeout, evt_cts_change} = '0;
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(3'd0, 11'h012, "R1");
    chk(3'd1, 11'h000, "R1");
    chk(3'd2, 11'h000, "R1");
    chk_irq(1'b0, "R1");

    // R6 mask write/read, unused bits dropped
    wr(3'd1, 11'h7FF);
    chk(3'd1, 11'h7F2, "R6");
    wr(3'd1, 11'h000);
    chk(3'd1, 11'h000, "R6");

    // R3 receive crossing at default trigger 8
    for (int v = 1; v <= 7; v++) set_rx(v);
    chk(3'd2, 11'h000, "R3");
    set_rx(8);
    chk(3'd2, 11'h010, "R3");
    wr(3'd4, 11'h010);
    set_rx(9); set_rx(10);
    chk(3'd2, 11'h000, "R3");
    set_rx(0);

    // R4 transmit crossing at default trigger 8
    set_tx(16);
    for (int v = 15; v >= 9; v--) set_tx(v);
    chk(3'd2, 11'h000, "R4");
    set_tx(8);
    chk(3'd2, 11'h020, "R4");
    wr(3'd4, 11'h020);
    set_tx(7);
    chk(3'd2, 11'h000, "R4");

    // R2 trigger codes
    wr(3'd0, 11'h002);
    chk(3'd0, 11'h002, "R2");
    set_rx(1);
    chk(3'd2, 11'h000, "R2");
    set_rx(2);
    chk(3'd2, 11'h010, "R2");
    wr(3'd4, 11'h010); set_rx(0);
    wr(3'd0, 11'h022);
    set_rx(13);
    chk(3'd2, 11'h000, "R2");
    set_rx(14);
    chk(3'd2, 11'h010, "R2");
    wr(3'd4, 11'h010); set_rx(0);
    wr(3'd0, 11'h03A);
    set_rx(7);
    chk(3'd2, 11'h000, "R2");
    set_rx(8);
    chk(3'd2, 11'h010, "R2");
    wr(3'd4, 11'h010); set_rx(0);
    wr(3'd0, 11'h010);
    set_tx(3);
    chk(3'd2, 11'h000, "R2");
    set_tx(2);
    chk(3'd2, 11'h020, "R2");
    wr(3'd4, 11'h020);

    // R5 event sources
    pulse(10, 0, '0); pulse(9, 0, '0); pulse(8, 0, '0);
    pulse(7, 0, '0);  pulse(6, 0, '0); pulse(1, 0, '0);
    chk(3'd2, 11'h7C2, "R5");
    wr(3'd4, 11'h7FF);
    chk(3'd2, 11'h000, "R5");

    // R8 clear semantics
    pulse(10, 0, '0);
    wr(3'd4, 11'h000);
    chk(3'd2, 11'h400, "R8");
    wr(3'd4, 11'h3FF);
    chk(3'd2, 11'h400, "R8");
    wr(3'd4, 11'h400);
    chk(3'd2, 11'h000, "R8");

    // R9 event and clear together
    pulse(9, 1, 11'h200);
    chk(3'd2, 11'h200, "R9");
    wr(3'd4, 11'h200);

    // R7 / R10 masking and combined line
    pulse(8, 0, '0); pulse(7, 0, '0);
    chk(3'd3, 11'h000, "R7");
    chk_irq(1'b0, "R10");
    wr(3'd1, 11'h080);
    chk(3'd3, 11'h080, "R7");
    chk_irq(1'b1, "R10");
    wr(3'd1, 11'h600);
    chk(3'd3, 11'h000, "R7");
    chk_irq(1'b0, "R10");
    wr(3'd1, 11'h7F2);
    chk(3'd3, 11'h180, "R7");
    chk_irq(1'b1, "R10");

    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule